// File: doc/BRIEF.md
# Access Violation Interrupt Monitor

This block sits beside a memory permission checker that serves up to 32 bus masters. For each access, the block tells the checker whether that access must be checked. It does this by looking up the issuing master in a per-master bypass register. When the checker reports a permission failure, the block records the failure in a level interrupt. A second flag marks that more failures arrived before software cleared the first one.

Software reaches the block through a small register port. The status word holds the active flag and the repeat flag. A write of any value to the clear location drops both flags. The bypass word selects, bit by bit, which masters skip checking. Every master starts in bypass after reset.

The checker drives a one-cycle failure strobe together with the ID of the failing master. The register port is plain control: a write happens in every cycle where the write enable is high, and read data is a combinational function of the address. The port has no handshake and never stalls.

Top module: `acc_fault_irq_mon`

## Requirements
- R1: After reset, the status word reads 0x00000000, the bypass word reads 0xFFFFFFFF and `irq` is 0.
- R2: A failure strobe from a master whose bypass bit is 0 sets the active flag (status bit 0) on the next clock edge. `irq` equals the active flag at all times.
- R3: The repeat flag (status bit 1) is set when a failure is accepted while the active flag is already 1. The first accepted failure leaves it at 0.
- R4: A write of any data to offset 0x14 clears both status flags on the next edge. Offset 0x14 always reads 0.
- R5: If an accepted failure and a clear write fall in the same cycle, the block applies the clear first. The active flag ends at 1 and the repeat flag ends at 0.
- R6: A failure strobe from a master whose bypass bit is 1 changes neither flag. The block uses the bypass bit held before any bypass write in the same cycle.
- R7: The bypass word at offset 0x18 is writable and reads back what was written. Bit n belongs to master ID n.
- R8: `chk_req` is the inverse of the bypass bit selected by `acc_mst_id`, with no clock delay.
- R9: The status word is at offset 0x10. Its bits 31:2 read as 0.
- R10: Reads from any other offset return 0. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_vld | input | 1 | One-cycle permission failure strobe |
| flt_mst_id | input | 5 | ID of the master that failed |
| acc_mst_id | input | 5 | ID of the master issuing the current access |
| chk_req | output | 1 | High when the current access must be checked |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt, high while the active flag is set |

## Verification
The assertions check the following on every cycle:
- how the flags react to a clear write, to an accepted failure and to an ignored one;
- that the repeat flag never stands without the active flag;
- that `irq` and `chk_req` track the flag and bypass state.

Only the bench scenarios show the software-visible results. These are the read-back values of each offset, the reset contents, and that unmapped writes leave the bypass and status words untouched. The scenarios also cover the ordering cases: a clear together with a failure, and a bypass write together with a failure from the master being changed.

// File: rtl/afim_pkg.sv
package afim_pkg;
  // Default register byte offsets
  localparam logic [7:0] OFF_STS_D = 8'h10;
  localparam logic [7:0] OFF_CLR_D = 8'h14;
  localparam logic [7:0] OFF_BYP_D = 8'h18;

  // Failure tracking state
  typedef struct packed {
    logic ovr;  // repeat failure since last clear
    logic act;  // interrupt active
  } flt_sts_t;
endpackage

// File: rtl/afim_reg_if.sv
module afim_reg_if
  import afim_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned N_MST   = 32,
  parameter logic [AW-1:0] OFF_STS = AW'(OFF_STS_D),
  parameter logic [AW-1:0] OFF_CLR = AW'(OFF_CLR_D),
  parameter logic [AW-1:0] OFF_BYP = AW'(OFF_BYP_D)
) (
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [DW-1:0]    reg_wdata,
  input  flt_sts_t         sts,
  input  logic [N_MST-1:0] byp_q,
  output logic             clr_pls,
  output logic             byp_we,
  output logic [N_MST-1:0] byp_wdata,
  output logic [DW-1:0]    reg_rdata
);
  logic hit_sts, hit_clr, hit_byp;

  assign hit_sts = (reg_addr == OFF_STS);
  assign hit_clr = (reg_addr == OFF_CLR);
  assign hit_byp = (reg_addr == OFF_BYP);

  assign clr_pls   = reg_we && hit_clr;
  assign byp_we    = reg_we && hit_byp;
  assign byp_wdata = reg_wdata[N_MST-1:0];

  always_comb begin
    reg_rdata = '0;
    if (hit_sts) begin
      reg_rdata[0] = sts.act;
      reg_rdata[1] = sts.ovr;
    end else if (hit_byp) begin
      reg_rdata[N_MST-1:0] = byp_q;
    end
  end
endmodule

// File: rtl/afim_fault_trk.sv
module afim_fault_trk
  import afim_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flt_hit,
  input  logic     clr_pls,
  output flt_sts_t sts_q
);
  flt_sts_t sts_d;

  // Clear first, then fold in this cycle's failure
  always_comb begin
    sts_d = sts_q;
    if (clr_pls) begin
      sts_d.act = 1'b0;
      sts_d.ovr = 1'b0;
    end
    if (flt_hit) begin
      sts_d.ovr = sts_d.ovr | sts_d.act;
      sts_d.act = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end
endmodule

// File: rtl/afim_byp_ctl.sv
module afim_byp_ctl #(
  parameter int unsigned N_MST = 32,
  parameter int unsigned IDW   = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byp_we,
  input  logic [N_MST-1:0] byp_wdata,
  input  logic             flt_vld,
  input  logic [IDW-1:0]   flt_mst_id,
  input  logic [IDW-1:0]   acc_mst_id,
  output logic [N_MST-1:0] byp_q,
  output logic             flt_hit,
  output logic             chk_req
);
  // One enable flop per master, reset to bypass
  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      byp_q[m] <= 1'b1;
      else if (byp_we) byp_q[m] <= byp_wdata[m];
    end
  end

  assign flt_hit = flt_vld && !byp_q[flt_mst_id];
  assign chk_req = !byp_q[acc_mst_id];
endmodule

// File: rtl/acc_fault_irq_mon.sv
module acc_fault_irq_mon
  import afim_pkg::*;
#(
  parameter int unsigned N_MST = 32,
  parameter int unsigned IDW   = (N_MST > 1) ? $clog2(N_MST) : 1,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter logic [AW-1:0] OFF_STS = AW'(OFF_STS_D),
  parameter logic [AW-1:0] OFF_CLR = AW'(OFF_CLR_D),
  parameter logic [AW-1:0] OFF_BYP = AW'(OFF_BYP_D)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flt_vld,
  input  logic [IDW-1:0] flt_mst_id,
  input  logic [IDW-1:0] acc_mst_id,
  output logic           chk_req,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_we,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq
);
  flt_sts_t         sts_q;
  logic             sts_act, sts_ovr;
  logic [N_MST-1:0] byp_q;
  logic [N_MST-1:0] byp_wdata;
  logic             byp_we, clr_pls, flt_hit;

  afim_reg_if #(
    .AW(AW), .DW(DW), .N_MST(N_MST),
    .OFF_STS(OFF_STS), .OFF_CLR(OFF_CLR), .OFF_BYP(OFF_BYP)
  ) u_reg_if (
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .sts      (sts_q),
    .byp_q    (byp_q),
    .clr_pls  (clr_pls),
    .byp_we   (byp_we),
    .byp_wdata(byp_wdata),
    .reg_rdata(reg_rdata)
  );

  afim_byp_ctl #(.N_MST(N_MST), .IDW(IDW)) u_byp_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .byp_we    (byp_we),
    .byp_wdata (byp_wdata),
    .flt_vld   (flt_vld),
    .flt_mst_id(flt_mst_id),
    .acc_mst_id(acc_mst_id),
    .byp_q     (byp_q),
    .flt_hit   (flt_hit),
    .chk_req   (chk_req)
  );

  afim_fault_trk u_fault_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .flt_hit(flt_hit),
    .clr_pls(clr_pls),
    .sts_q  (sts_q)
  );

  assign sts_act = sts_q.act;
  assign sts_ovr = sts_q.ovr;
  assign irq     = sts_act;
endmodule

// File: rtl/afim_chk.sv
module afim_chk #(
  parameter int unsigned N_MST = 32,
  parameter int unsigned IDW   = 5,
  parameter int unsigned AW    = 8,
  parameter logic [AW-1:0] OFF_CLR = 8'h14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flt_vld,
  input logic [IDW-1:0]   flt_mst_id,
  input logic [IDW-1:0]   acc_mst_id,
  input logic             chk_req,
  input logic [AW-1:0]    reg_addr,
  input logic             reg_we,
  input logic             irq,
  input logic             sts_act,
  input logic             sts_ovr,
  input logic [N_MST-1:0] byp_q
);
  logic clr_w;
  assign clr_w = reg_we && (reg_addr == OFF_CLR);

  // R2
  acc_sets_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && !byp_q[flt_mst_id]) |=> sts_act);

  // R2
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == sts_act);

  // R3
  repeat_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && !byp_q[flt_mst_id] && sts_act && !clr_w) |=> sts_ovr);

  // R3
  ovr_needs_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_ovr |-> sts_act);

  // R4
  clr_drops_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> !sts_ovr);

  // R4
  clr_idle_drops_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !flt_vld) |=> !sts_act);

  // R6
  bypassed_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && byp_q[flt_mst_id] && !clr_w) |=> ($stable(sts_act) && $stable(sts_ovr)));

  // R8
  chk_req_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req == !byp_q[acc_mst_id]);
endmodule

bind acc_fault_irq_mon afim_chk #(
  .N_MST(N_MST), .IDW(IDW), .AW(AW), .OFF_CLR(OFF_CLR)
) u_afim_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flt_vld   (flt_vld),
  .flt_mst_id(flt_mst_id),
  .acc_mst_id(acc_mst_id),
  .chk_req   (chk_req),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .irq       (irq),
  .sts_act   (sts_act),
  .sts_ovr   (sts_ovr),
  .byp_q     (byp_q)
);

// File: tb/test_acc_fault_irq_mon.sv
module test_acc_fault_irq_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_vld = 1'b0;
  logic [4:0]  flt_mst_id = '0;
  logic [4:0]  acc_mst_id = '0;
  logic        chk_req;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  localparam logic [7:0] A_STS = 8'h10, A_CLR = 8'h14, A_BYP = 8'h18;

  always #4 clk = ~clk;

  acc_fault_irq_mon i_acc_fault_irq_mon (
    .clk(clk), .rst_n(rst_n), .flt_vld(flt_vld), .flt_mst_id(flt_mst_id),
    .acc_mst_id(acc_mst_id), .chk_req(chk_req), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Inputs change at negedge; one step commits them at the next posedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    flt_vld = 1'b0;
    reg_we  = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
  endtask

  task automatic fail(logic [4:0] id);
    flt_mst_id = id; flt_vld = 1'b1;
    step();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STS, d); chk("R1 status after reset", d, 32'h0);
    rd(A_BYP, d); chk("R1 bypass after reset", d, 32'hFFFF_FFFF);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    acc_mst_id = 5'd7; #1;
    chk("R8 chk_req with default bypass", {31'b0, chk_req}, 32'h0);
  endtask

  task automatic t_default_bypass_ignored();
    logic [31:0] d;
    fail(5'd3);
    rd(A_STS, d); chk("R6 failure of bypassed master ignored", d, 32'h0);
  endtask

  task automatic t_bypass_rw();
    logic [31:0] d;
    wr(A_BYP, 32'hFFFF_FFF6);  // masters 0 and 3 checked
    rd(A_BYP, d); chk("R7 bypass readback", d, 32'hFFFF_FFF6);
    acc_mst_id = 5'd3; #1; chk("R8 chk_req master 3", {31'b0, chk_req}, 32'h1);
    acc_mst_id = 5'd1; #1; chk("R8 chk_req master 1", {31'b0, chk_req}, 32'h0);
    acc_mst_id = 5'd0; #1; chk("R8 chk_req master 0", {31'b0, chk_req}, 32'h1);
    acc_mst_id = 5'd31; #1; chk("R8 chk_req master 31", {31'b0, chk_req}, 32'h0);
  endtask

  task automatic t_first_and_repeat();
    logic [31:0] d;
    fail(5'd3);
    rd(A_STS, d); chk("R2/R3 first failure: active only", d, 32'h1);
    chk("R2 irq high", {31'b0, irq}, 32'h1);
    fail(5'd1);  // still bypassed
    rd(A_STS, d); chk("R6 bypassed master adds no repeat", d, 32'h1);
    fail(5'd0);
    rd(A_STS, d); chk("R3 repeat failure sets overrun", d, 32'h3);
    fail(5'd3);
    rd(A_STS, d); chk("R3 third failure keeps both", d, 32'h3);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A_CLR, 32'hDEAD_BEEF);
    rd(A_STS, d); chk("R4 clear drops both flags", d, 32'h0);
    chk("R4 irq low after clear", {31'b0, irq}, 32'h0);
    rd(A_CLR, d); chk("R4 clear offset reads zero", d, 32'h0);
  endtask

  task automatic t_clear_collide();
    logic [31:0] d;
    fail(5'd0);
    fail(5'd0);
    rd(A_STS, d); chk("R3 setup overrun before collide", d, 32'h3);
    reg_addr = A_CLR; reg_wdata = 32'h0; reg_we = 1'b1;
    flt_mst_id = 5'd3; flt_vld = 1'b1;
    step();
    rd(A_STS, d); chk("R5 clear then failure same cycle", d, 32'h1);
    wr(A_CLR, 32'h1);
  endtask

  task automatic t_byp_write_collide();
    logic [31:0] d;
    // master 5 bypassed now; unbypass it in the same cycle as its failure
    reg_addr = A_BYP; reg_wdata = 32'hFFFF_FFD6; reg_we = 1'b1;
    flt_mst_id = 5'd5; flt_vld = 1'b1;
    step();
    rd(A_STS, d); chk("R6 old bypass bit used for same-cycle failure", d, 32'h0);
    fail(5'd5);
    rd(A_STS, d); chk("R2 master 5 now checked", d, 32'h1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h1C, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h1C, d); chk("R10 unmapped read", d, 32'h0);
    rd(8'h04, d); chk("R10 unmapped read low", d, 32'h0);
    rd(A_BYP, d); chk("R10 bypass untouched", d, 32'hFFFF_FFD6);
    rd(A_STS, d); chk("R9 status bits 31:2 zero, flags kept", d, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_bypass_ignored();
    t_bypass_rw();
    t_first_and_repeat();
    t_clear();
    t_clear_collide();
    t_byp_write_collide();
    t_unmapped();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule